// File: doc/BRIEF.md
# Clock-Synchronous Byte Serial Transceiver

This block moves one byte at a time over a three-wire synchronous serial link: a clock line, a data output line and a data input line. Eight bits leave on the output line while eight bits arrive on the input line. The host side is four bits wide. One command loads the byte shifter from an upper and a lower nibble. The shifter can be read back as the same two nibbles at any time.

A four-bit mode register sets how the block runs. One bit chooses the clock source: the block can generate the serial clock from an instruction-cycle enable, or it can follow clock edges that arrive on the pin. A second bit chooses the internal clock rate, either the instruction rate divided by four or divided by eight. A third bit decides whether the three pins belong to the link or remain plain inputs. The fourth bit is a spare that stores whatever is written to it. When a transfer ends, a completion flag is set and an interrupt pulse is raised. The raw pin levels can always be read, whatever the mode.

Top module: `sio8_xcvr`

## Requirements
- R1: After reset the mode register reads 0000, the completion flag and interrupt are 0, the shifter reads 0x00, SCK output is 1, both output enables are 0 and the data output is 1.
- R2: All four mode bits are stored on a write and read back unchanged, including the spare bit 3.
- R3: When idle, a load places hi_nib in shifter bits 7..4 and lo_nib in bits 3..0, clears the completion flag and arms a transfer; the shifter then holds still until a clock edge arrives.
- R4: With mode bit 0 = 1 the block makes its own clock. Its half period is 2 enables of icyc_en when mode bit 2 = 1 (divide by 4) and 4 enables when bit 2 = 0 (divide by 8), so a transfer takes 32 or 64 enables.
- R5: Data goes LSB first. On each falling SCK edge the data output takes shifter bit 0. On each rising edge the shifter moves right and the sampled input enters bit 7, so the first bit received ends in bit 0.
- R6: The eighth rising edge ends the transfer. The completion flag is set and stays set until the next accepted load, and done_irq is high for exactly one clock, in the cycle the flag rises.
- R7: With mode bit 0 = 0 and bit 1 = 1, the block is clocked by edges on pad_in[0], which pass through a two-flop synchronizer; pad_in[2] is synchronized the same way. The block does not drive SCK (sck_oe = 0).
- R8: With mode bit 1 = 0, both output enables are 0, SCK output stays 1, edges on pad_in[0] are ignored, and the serial input reads as 1.
- R9: port_rd always equals pad_in (bit 0 clock pin, bit 1 data-out pin, bit 2 data-in pin), in every mode.
- R10: A read during a transfer returns the partly shifted contents. A load during a transfer is ignored.
- R11: sck_oe = mode bit 1 AND mode bit 0, sdo_oe = mode bit 1, and SCK output is 1 whenever no transfer is running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| icyc_en | input | 1 | Instruction-cycle enable, one clock per instruction cycle |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 4 | Mode write data |
| mode_q | output | 4 | Mode register contents |
| load_en | input | 1 | Load shifter from hi_nib/lo_nib |
| hi_nib | input | 4 | Upper nibble for a load |
| lo_nib | input | 4 | Lower nibble for a load |
| sr_hi | output | 4 | Shifter bits 7..4 |
| sr_lo | output | 4 | Shifter bits 3..0 |
| pad_in | input | 3 | Pin input levels: clock, data-out pin, data-in |
| port_rd | output | 3 | Raw pin levels for general-purpose reads |
| sck_out | output | 1 | Serial clock drive level |
| sck_oe | output | 1 | Serial clock output enable |
| sdo_out | output | 1 | Serial data output level |
| sdo_oe | output | 1 | Serial data output enable |
| done_flag | output | 1 | Transfer complete flag |
| done_irq | output | 1 | One-clock completion interrupt pulse |

## Verification
On every cycle the assertions check the load effect on the shifter and flag, that an idle shifter does not move, the one-clock interrupt and how it lines up with the flag, that the flag holds, that a load during a transfer does not restart anything, and the idle-high clock with its pin gating. Only the bench scenarios can show the bit order on the data line, the captured input byte, transfer length at each divide ratio, the synchronized external clock path, partial readback, and the 0xFF result when the pins are not assigned. These scenarios sweep all mode values, all pin levels, and several byte patterns at both internal rates and with an external clock.

// File: rtl/sio8_pkg.sv
package sio8_pkg;

  localparam int MODE_W = 4;

  // Bit order is behaviour: bit0 clock source, bit1 pin assign,
  // bit2 rate select, bit3 spare storage.
  typedef struct packed {
    logic spare;
    logic div_fast;
    logic pins_on;
    logic int_clk;
  } sio_mode_t;

  // Instruction-cycle enables per half period of the internal clock.
  function automatic int unsigned half_ticks(input logic fast,
                                             input int unsigned div_slow,
                                             input int unsigned div_quick);
    return fast ? (div_quick / 2) : (div_slow / 2);
  endfunction

  // Enables consumed by a whole transfer of nbits.
  function automatic int unsigned xfer_ticks(input logic fast,
                                             input int unsigned div_slow,
                                             input int unsigned div_quick,
                                             input int unsigned nbits);
    return 2 * nbits * half_ticks(fast, div_slow, div_quick);
  endfunction

endpackage

// File: rtl/sio8_mode_reg.sv
module sio8_mode_reg
  import sio8_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [MODE_W-1:0] wr_data,
  output sio_mode_t         mode
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= '0;
    end else if (wr_en) begin
      mode <= sio_mode_t'(wr_data);
    end
  end

endmodule

// File: rtl/sio8_sync.sv
module sio8_sync #(
  parameter int          WIDTH   = 2,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/sio8_clkgen.sv
module sio8_clkgen
  import sio8_pkg::*;
#(
  parameter int unsigned DIV_SLOW = 8,
  parameter int unsigned DIV_FAST = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  input  logic fast,
  output logic sck_q,
  output logic fall_ev,
  output logic rise_ev
);

  localparam int unsigned HALF_MAX = (DIV_SLOW > DIV_FAST) ? DIV_SLOW / 2 : DIV_FAST / 2;
  localparam int CW = (HALF_MAX > 1) ? $clog2(HALF_MAX) : 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_last;
  logic          wrap;

  assign cnt_last = CW'(half_ticks(fast, DIV_SLOW, DIV_FAST) - 1);
  assign wrap     = run && tick && (cnt == cnt_last);
  assign fall_ev  = wrap && sck_q;
  assign rise_ev  = wrap && !sck_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      sck_q <= 1'b1;
    end else if (!run) begin
      cnt   <= '0;
      sck_q <= 1'b1;
    end else if (tick) begin
      if (wrap) begin
        cnt   <= '0;
        sck_q <= ~sck_q;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/sio8_shifter.sv
module sio8_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_req,
  input  logic [DATA_W-1:0] load_word,
  input  logic              fall_ev,
  input  logic              rise_ev,
  input  logic              sin,
  output logic [DATA_W-1:0] sr_q,
  output logic              sdo_q,
  output logic              busy,
  output logic              done_flag,
  output logic              done_irq,
  output logic              load_ok,
  output logic              last_ev
);

  localparam int CW = (DATA_W > 2) ? $clog2(DATA_W) : 1;

  logic [CW-1:0] bit_cnt;

  function automatic logic [DATA_W-1:0] shift_in(input logic [DATA_W-1:0] w, input logic b);
    return {b, w[DATA_W-1:1]};
  endfunction

  assign load_ok = load_req && !busy;
  assign last_ev = busy && rise_ev && (bit_cnt == CW'(DATA_W - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q      <= '0;
      sdo_q     <= 1'b1;
      busy      <= 1'b0;
      bit_cnt   <= '0;
      done_flag <= 1'b0;
      done_irq  <= 1'b0;
    end else begin
      done_irq <= 1'b0;
      if (load_ok) begin
        sr_q      <= load_word;
        busy      <= 1'b1;
        bit_cnt   <= '0;
        done_flag <= 1'b0;
      end else if (busy) begin
        if (fall_ev) sdo_q <= sr_q[0];
        if (rise_ev) begin
          sr_q    <= shift_in(sr_q, sin);
          bit_cnt <= bit_cnt + 1'b1;
        end
        if (last_ev) begin
          busy      <= 1'b0;
          done_flag <= 1'b1;
          done_irq  <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/sio8_xcvr.sv
module sio8_xcvr
  import sio8_pkg::*;
#(
  parameter int          NIB_W       = 4,
  parameter int unsigned DIV_SLOW    = 8,
  parameter int unsigned DIV_FAST    = 4,
  parameter int          SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              icyc_en,
  input  logic              mode_we,
  input  logic [MODE_W-1:0] mode_wdata,
  output logic [MODE_W-1:0] mode_q,
  input  logic              load_en,
  input  logic [NIB_W-1:0]  hi_nib,
  input  logic [NIB_W-1:0]  lo_nib,
  output logic [NIB_W-1:0]  sr_hi,
  output logic [NIB_W-1:0]  sr_lo,
  input  logic [2:0]        pad_in,
  output logic [2:0]        port_rd,
  output logic              sck_out,
  output logic              sck_oe,
  output logic              sdo_out,
  output logic              sdo_oe,
  output logic              done_flag,
  output logic              done_irq
);

  localparam int DATA_W  = 2 * NIB_W;
  localparam int PAD_SCK = 0;
  localparam int PAD_SI  = 2;

  sio_mode_t mode;

  // named internal events for the checker
  logic xfer_busy;
  logic load_accept;
  logic last_shift;

  logic              int_sck, int_fall, int_rise;
  logic [1:0]        pin_s;
  logic              sck_s, si_s, sck_prev;
  logic              ext_fall, ext_rise, ext_path;
  logic              fall_ev, rise_ev, sin_eff;
  logic [DATA_W-1:0] sr_q;
  logic              sdo_q;

  sio8_mode_reg u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (mode_we),
    .wr_data (mode_wdata),
    .mode    (mode)
  );

  sio8_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({pad_in[PAD_SI], pad_in[PAD_SCK]}),
    .q     (pin_s)
  );

  assign sck_s = pin_s[0];
  assign si_s  = pin_s[1];

  always_ff @(posedge clk) begin
    if (!rst_n) sck_prev <= 1'b1;
    else        sck_prev <= sck_s;
  end

  assign ext_path = mode.pins_on && !mode.int_clk;
  assign ext_fall = ext_path && sck_prev && !sck_s;
  assign ext_rise = ext_path && !sck_prev && sck_s;

  sio8_clkgen #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) u_clkgen (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (xfer_busy && mode.int_clk),
    .tick    (icyc_en),
    .fast    (mode.div_fast),
    .sck_q   (int_sck),
    .fall_ev (int_fall),
    .rise_ev (int_rise)
  );

  assign fall_ev = mode.int_clk ? int_fall : ext_fall;
  assign rise_ev = mode.int_clk ? int_rise : ext_rise;
  assign sin_eff = mode.pins_on ? si_s : 1'b1;

  sio8_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_req  (load_en),
    .load_word ({hi_nib, lo_nib}),
    .fall_ev   (fall_ev),
    .rise_ev   (rise_ev),
    .sin       (sin_eff),
    .sr_q      (sr_q),
    .sdo_q     (sdo_q),
    .busy      (xfer_busy),
    .done_flag (done_flag),
    .done_irq  (done_irq),
    .load_ok   (load_accept),
    .last_ev   (last_shift)
  );

  assign mode_q  = mode;
  assign sr_hi   = sr_q[DATA_W-1 -: NIB_W];
  assign sr_lo   = sr_q[NIB_W-1:0];
  assign port_rd = pad_in;
  assign sck_oe  = mode.pins_on && mode.int_clk;
  assign sck_out = sck_oe ? int_sck : 1'b1;
  assign sdo_oe  = mode.pins_on;
  assign sdo_out = sdo_q;

endmodule

// File: rtl/sio8_checker.sv
module sio8_checker #(
  parameter int NIB_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load_en,
  input logic [NIB_W-1:0] hi_nib,
  input logic [NIB_W-1:0] lo_nib,
  input logic [3:0]       mode_q,
  input logic [NIB_W-1:0] sr_hi,
  input logic [NIB_W-1:0] sr_lo,
  input logic             sck_out,
  input logic             sck_oe,
  input logic             sdo_oe,
  input logic             done_flag,
  input logic             done_irq,
  input logic             busy,
  input logic             load_accept,
  input logic             last_shift
);

  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_accept |=> ({sr_hi, sr_lo} == $past({hi_nib, lo_nib})) && !done_flag && busy);

  p_idle_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !load_en |=> $stable({sr_hi, sr_lo}));

  p_irq_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq);

  p_irq_with_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> done_irq);

  p_last_sets_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    last_shift |=> done_flag && !busy);

  p_flag_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_flag && !load_en |=> done_flag);

  p_busy_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && load_en |=> busy || done_flag);

  p_sck_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sck_out);

  p_pins_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q[1] |-> !sck_oe && !sdo_oe && sck_out);

endmodule

bind sio8_xcvr sio8_checker #(.NIB_W(NIB_W)) u_sio8_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .load_en     (load_en),
  .hi_nib      (hi_nib),
  .lo_nib      (lo_nib),
  .mode_q      (mode_q),
  .sr_hi       (sr_hi),
  .sr_lo       (sr_lo),
  .sck_out     (sck_out),
  .sck_oe      (sck_oe),
  .sdo_oe      (sdo_oe),
  .done_flag   (done_flag),
  .done_irq    (done_irq),
  .busy        (xfer_busy),
  .load_accept (load_accept),
  .last_shift  (last_shift)
);

// File: tb/test_sio8_xcvr.sv
module test_sio8_xcvr;

  localparam int CLK_PERIOD = 10;
  localparam int ICYC_DIV   = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       icyc_en = 1'b0;
  logic       mode_we = 1'b0;
  logic [3:0] mode_wdata = '0;
  logic [3:0] mode_q;
  logic       load_en = 1'b0;
  logic [3:0] hi_nib = '0, lo_nib = '0;
  logic [3:0] sr_hi, sr_lo;
  logic       pad_sck = 1'b1, pad_so = 1'b1, pad_si = 1'b1;
  logic [2:0] port_rd;
  logic       sck_out, sck_oe, sdo_out, sdo_oe, done_flag, done_irq;

  int checks = 0;
  int errors = 0;
  int irq_cnt = 0;
  int icyc_phase = 0;
  bit finished = 0;

  sio8_xcvr i_sio8_xcvr (
    .clk(clk), .rst_n(rst_n), .icyc_en(icyc_en),
    .mode_we(mode_we), .mode_wdata(mode_wdata), .mode_q(mode_q),
    .load_en(load_en), .hi_nib(hi_nib), .lo_nib(lo_nib),
    .sr_hi(sr_hi), .sr_lo(sr_lo),
    .pad_in({pad_si, pad_so, pad_sck}), .port_rd(port_rd),
    .sck_out(sck_out), .sck_oe(sck_oe), .sdo_out(sdo_out), .sdo_oe(sdo_oe),
    .done_flag(done_flag), .done_irq(done_irq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  initial begin
    forever begin
      @(negedge clk);
      icyc_en = (icyc_phase == ICYC_DIV - 1);
      icyc_phase = (icyc_phase + 1) % ICYC_DIV;
    end
  end

  always @(negedge clk) if (rst_n && done_irq) irq_cnt++;

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_mode(input logic [3:0] m);
    @(negedge clk);
    mode_wdata = m;
    mode_we = 1'b1;
    @(negedge clk);
    mode_we = 1'b0;
  endtask

  task automatic do_load(input logic [7:0] w);
    @(negedge clk);
    hi_nib = w[7:4];
    lo_nib = w[3:0];
    load_en = 1'b1;
    @(negedge clk);
    load_en = 1'b0;
  endtask

  function automatic int partial(input logic [7:0] tx, input logic [7:0] rx, input int k);
    return ((int'(tx) >> k) | ((int'(rx) & ((1 << k) - 1)) << (8 - k))) & 255;
  endfunction

  // internal-clock transfer; mode must already select the internal clock
  task automatic int_xfer(input logic [7:0] tx, input logic [7:0] rx,
                          input logic fast, input int probe_k);
    int k = 0, cyc = 0, bad_bits = 0, irq0, half, expc;
    logic prev = 1'b1;
    half = fast ? 2 : 4;
    expc = 48 * half;
    do_load(tx);
    irq0 = irq_cnt;
    check({sr_hi, sr_lo} == tx, "R3 load", {sr_hi, sr_lo}, tx);
    check(!done_flag, "R3 flag cleared by load", done_flag, 0);
    while (!done_flag && cyc < 1000) begin
      @(negedge clk);
      load_en = 1'b0;
      cyc++;
      if (prev && !sck_out) begin
        if (sdo_out !== tx[k]) bad_bits++;
        pad_si = rx[k];
      end
      if (!prev && sck_out) begin
        k++;
        if (k == probe_k) begin
          check({sr_hi, sr_lo} == partial(tx, rx, k), "R10 partial read",
                {sr_hi, sr_lo}, partial(tx, rx, k));
          hi_nib = 4'h9; lo_nib = 4'h9; load_en = 1'b1;
        end
      end
      prev = sck_out;
    end
    load_en = 1'b0;
    check(bad_bits == 0, "R5 lsb-first output bits", bad_bits, 0);
    check({sr_hi, sr_lo} == rx, "R5 received byte", {sr_hi, sr_lo}, rx);
    check(done_flag, "R6 flag set", done_flag, 1);
    check(cyc >= expc - 3 && cyc <= expc + 1, "R4 transfer length", cyc, expc);
    if (probe_k > 0)
      check({sr_hi, sr_lo} == rx, "R10 busy load ignored", {sr_hi, sr_lo}, rx);
    tick(3);
    check(irq_cnt - irq0 == 1, "R6 one irq pulse", irq_cnt - irq0, 1);
    check(done_flag && sck_out, "R11 idle high, flag held", {done_flag, sck_out}, 3);
    pad_si = 1'b1;
  endtask

  // external-clock transfer driven by the bench on pad_sck
  task automatic ext_xfer(input logic [7:0] tx, input logic [7:0] rx);
    int bad_bits = 0, irq0;
    do_load(tx);
    irq0 = irq_cnt;
    check(!done_flag, "R3 flag cleared by load", done_flag, 0);
    for (int k = 0; k < 8; k++) begin
      pad_sck = 1'b0;
      tick(6);
      if (sdo_out !== tx[k] || sck_oe !== 1'b0) bad_bits++;
      pad_si = rx[k];
      tick(3);
      pad_sck = 1'b1;
      tick(6);
    end
    check(bad_bits == 0, "R7 external bits out", bad_bits, 0);
    check({sr_hi, sr_lo} == rx, "R7 external byte in", {sr_hi, sr_lo}, rx);
    check(done_flag, "R6 flag after external", done_flag, 1);
    check(irq_cnt - irq0 == 1, "R6 one irq external", irq_cnt - irq0, 1);
    pad_si = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    logic [7:0] pats [6];
    pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5;
    pats[3] = 8'h3C; pats[4] = 8'h81; pats[5] = 8'h6E;

    tick(4);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    check(mode_q == 4'h0, "R1 mode", mode_q, 0);
    check({sr_hi, sr_lo} == 8'h00, "R1 shifter", {sr_hi, sr_lo}, 0);
    check(!done_flag && !done_irq, "R1 flag/irq", {done_flag, done_irq}, 0);
    check(sck_out && !sck_oe && !sdo_oe && sdo_out, "R1 pins",
          {sck_out, sck_oe, sdo_oe, sdo_out}, 4'b1001);

    // R2 / R11 mode sweep
    for (int m = 0; m < 16; m++) begin
      set_mode(4'(m));
      check(mode_q == 4'(m), "R2 mode readback", mode_q, m);
      check(sck_oe == (m[1] & m[0]) && sdo_oe == m[1], "R11 enables",
            {sck_oe, sdo_oe}, {m[1] & m[0], m[1]});
    end

    // R9 pad readback in two modes
    for (int pass = 0; pass < 2; pass++) begin
      set_mode(pass == 0 ? 4'h0 : 4'h3);
      for (int v = 0; v < 8; v++) begin
        @(negedge clk);
        {pad_si, pad_so, pad_sck} = 3'(v);
        #1;
        check(port_rd == 3'(v), "R9 pin readback", port_rd, v);
      end
    end
    @(negedge clk);
    {pad_si, pad_so, pad_sck} = 3'b111;
    tick(4);
    check({sr_hi, sr_lo} == 8'h00 && !done_flag, "R3 idle shifter holds",
          {sr_hi, sr_lo}, 0);

    // internal clock, both rates
    for (int i = 0; i < 6; i++) begin
      for (int f = 0; f < 2; f++) begin
        logic [7:0] rx;
        int pk;
        rx = {pats[i][3:0], pats[i][7:4]} ^ 8'hC3;
        pk = (i == 2 && f == 0) ? 3 : ((i == 3 && f == 1) ? 5 : 0);
        set_mode(f == 1 ? 4'h7 : 4'h3);
        int_xfer(pats[i], rx, f == 1, pk);
      end
    end

    // external clock, with and without the spare bit
    for (int i = 0; i < 3; i++) begin
      set_mode(i == 1 ? 4'hA : 4'h2);
      ext_xfer(pats[i + 2], ~pats[i + 3]);
    end

    // R8 pins unassigned: external edges ignored, input reads as 1
    set_mode(4'h0);
    do_load(8'h5A);
    check(!done_flag, "R3 flag cleared by load", done_flag, 0);
    for (int k = 0; k < 8; k++) begin
      pad_sck = 1'b0; pad_si = 1'b0;
      tick(6);
      pad_sck = 1'b1;
      tick(6);
    end
    check({sr_hi, sr_lo} == 8'h5A && !done_flag, "R8 pin edges ignored",
          {sr_hi, sr_lo}, 8'h5A);
    check(!sck_oe && !sdo_oe, "R8 enables off", {sck_oe, sdo_oe}, 0);
    set_mode(4'h5);
    begin
      int cyc = 0, hi_bad = 0;
      while (!done_flag && cyc < 1000) begin
        @(negedge clk);
        cyc++;
        if (sck_out !== 1'b1) hi_bad++;
      end
      check(hi_bad == 0, "R8 clock stays high", hi_bad, 0);
      check({sr_hi, sr_lo} == 8'hFF && done_flag, "R8 input reads one",
            {sr_hi, sr_lo}, 8'hFF);
    end
    pad_si = 1'b1;

    tick(4);
    report();
  end

endmodule